// File: doc/BRIEF.md
# Overcurrent Fast-Kill Shutdown Latch

This block sits between an overcurrent sense comparator and the gate logic of a half-bridge leg. It blocks the gates within the same cycle as the fault and keeps them blocked for a disable window that the shutdown pin sets. When the digital overcurrent flag rises, a combinational path forces the gate-kill output high at once. This path does not wait for a clock edge or for the shutdown pin to discharge, so the turn-off delay does not depend on the RC network outside the chip.

The same fault, once synchronised, moves a small state machine into a pulling state. In this state the block switches on the open-drain pulldown of the bidirectional, active-low shutdown pin. The pulldown stays latched until the fault has cleared and the synchronised pin level reads low. The machine then releases the pulldown and waits. The gates stay off until the external pull-up has recharged the pin to a high level. The disable time is therefore stretched past what the RC alone would give. A pin that is driven low from outside also blocks the gates at any time.

Top module: `fault_shutdown_latch`

## Requirements
- R1: While `fault_i` is 1, `gate_kill_o` is 1 in the same cycle, with no clock edge in between, in every state.
- R2: From idle, a fault held across the synchroniser moves the status to pulling (code 1) and sets `sd_pull_o` on the third rising edge after the fault appears (two synchroniser stages plus the state register).
- R3: In pulling, the status and `sd_pull_o` stay set for as long as the synchronised fault is 1 or the synchronised pin level is 1. They leave pulling only when both are 0.
- R4: On leaving pulling the status becomes waiting (code 2) and `sd_pull_o` clears. Waiting holds, and `gate_kill_o` stays 1, until the synchronised pin level reads 1. The status then becomes idle (code 0).
- R5: While `sd_pin_i` is 0, `gate_kill_o` is 1 in the same cycle, whatever the state.
- R6: A synchronised fault seen in waiting returns the status to pulling and turns the pulldown on again.
- R7: The status uses only codes 0 (idle), 1 (pulling) and 2 (waiting). `sd_pull_o` is 1 exactly when the status is pulling.
- R8: During and right after reset the status is idle and `sd_pull_o` is 0. The synchroniser presets to no fault and pin high, so `gate_kill_o` is 0 when `fault_i` is 0 and `sd_pin_i` is 1.
- R9: `gate_kill_o` is 0 only when the status is idle, `fault_i` is 0 and `sd_pin_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | 1 | Asynchronous overcurrent flag from the sense comparator, active high |
| sd_pin_i | input | 1 | Sensed level of the shutdown pin, low means shutdown |
| gate_kill_o | output | 1 | Forces both gate drives of the leg off when 1 |
| sd_pull_o | output | 1 | Enables the open-drain pulldown on the shutdown pin |
| state_o | output | 2 | Status: 0 idle, 1 pulling, 2 waiting |

## Verification
The bench targets the case where a fault pulse is gone before the pin has discharged. A design that released the latch on fault clear alone would drop the pulldown while the pin is still high. The bench also holds the fault past the moment the pin reads low. Here a design that watched only the pin would enter waiting too early. Other stimulus re-asserts the fault during waiting, which catches a machine that ignores it and lets the gates come back, and pulls the pin low from outside while idle, which catches a kill path that looks only at the state. One-cycle fault pulses check that the kill rises combinationally, because a registered kill would show up one edge late.

// File: rtl/fsl_pkg.sv
package fsl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PULL = 2'd1,
        ST_WAIT = 2'd2
    } fsl_state_e;

    typedef struct packed {
        fsl_state_e state;
        logic       pull;
    } fsl_regs_t;

endpackage

// File: rtl/fsl_sync.sv
module fsl_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/fsl_ctrl.sv
module fsl_ctrl
    import fsl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fault_s,
    input  logic       pin_s,
    output fsl_state_e state_o,
    output logic       pull_o
);
    fsl_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: if (fault_s) r_d.state = ST_PULL;
            ST_PULL: if (!fault_s && !pin_s) r_d.state = ST_WAIT;
            ST_WAIT: begin
                if (fault_s)    r_d.state = ST_PULL;
                else if (pin_s) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
        r_d.pull = (r_d.state == ST_PULL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, pull: 1'b0};
        else        r_q <= r_d;
    end

    assign state_o = r_q.state;
    assign pull_o  = r_q.pull;

    assert_enter_pull_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && fault_s) |=> (r_q.state == ST_PULL && r_q.pull));
    assert_hold_pull_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_PULL && (fault_s || pin_s)) |=> (r_q.state == ST_PULL));
    assert_hold_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAIT && !fault_s && !pin_s) |=> (r_q.state == ST_WAIT && !r_q.pull));
    assert_refault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAIT && fault_s) |=> (r_q.state == ST_PULL));
endmodule

// File: rtl/fault_shutdown_latch.sv
module fault_shutdown_latch
    import fsl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fault_i,
    input  logic       sd_pin_i,
    output logic       gate_kill_o,
    output logic       sd_pull_o,
    output logic [1:0] state_o
);
    logic       fault_s, pin_s;
    fsl_state_e st;

    fsl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_fault (
        .clk(clk), .rst_n(rst_n), .async_i(fault_i), .sync_o(fault_s));
    fsl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pin (
        .clk(clk), .rst_n(rst_n), .async_i(sd_pin_i), .sync_o(pin_s));

    fsl_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .fault_s(fault_s), .pin_s(pin_s),
        .state_o(st), .pull_o(sd_pull_o));

    // direct kill path: raw fault and raw pin, no clock in between
    assign gate_kill_o = fault_i | ~sd_pin_i | (st != ST_IDLE);
    assign state_o     = st;

    assert_kill_on_fault_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |-> gate_kill_o);
    assert_kill_on_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_pin_i |-> gate_kill_o);
    assert_pull_implies_kill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sd_pull_o |-> (gate_kill_o && state_o == 2'd1));
    assert_legal_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state_o != 2'd3);
endmodule

// File: tb/sim_fault_shutdown_latch.sv
`timescale 1ns/1ps
module sim_fault_shutdown_latch;
    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fault_i = 1'b0;
    logic       sd_pin_i = 1'b1;
    logic       gate_kill_o, sd_pull_o;
    logic [1:0] state_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference model
    logic [1:0]      m_st = 2'd0;
    logic [SYNC-1:0] m_f  = '0;
    logic [SYNC-1:0] m_p  = '1;

    always #4 clk = ~clk;

    fault_shutdown_latch #(.SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .sd_pin_i(sd_pin_i),
        .gate_kill_o(gate_kill_o), .sd_pull_o(sd_pull_o), .state_o(state_o));

    function automatic logic [1:0] next_st(logic [1:0] s, logic f, logic p);
        case (s)
            2'd0:    return f ? 2'd1 : 2'd0;
            2'd1:    return (!f && !p) ? 2'd2 : 2'd1;
            2'd2:    return f ? 2'd1 : (p ? 2'd0 : 2'd2);
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic exp_kill(logic [1:0] s, logic f, logic p);
        return f | ~p | (s != 2'd0);
    endfunction

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // drive at negedge, check settled outputs, then advance model over next posedge
    task automatic step(logic f, logic p, string kreq, string sreq);
        @(negedge clk);
        fault_i  = f;
        sd_pin_i = p;
        #1;
        chk(kreq, {3'b0, gate_kill_o}, {3'b0, exp_kill(m_st, f, p)});
        chk(sreq, {2'b0, state_o}, {2'b0, m_st});
        chk("R7", {3'b0, sd_pull_o}, {3'b0, m_st == 2'd1});
        if (state_o == 2'd3) chk("R7", 4'd3, 4'd0);
        m_st = next_st(m_st, m_f[SYNC-1], m_p[SYNC-1]);
        m_f  = {m_f[SYNC-2:0], f};
        m_p  = {m_p[SYNC-2:0], p};
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        // R8: reset state
        #3;
        chk("R8", {2'b0, state_o}, 4'd0);
        chk("R8", {3'b0, sd_pull_o}, 4'd0);
        chk("R8", {3'b0, gate_kill_o}, 4'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: idle quiet
        repeat (3) step(1'b0, 1'b1, "R9", "R8");
        // R1/R2: single-cycle pulse before pin discharges, then pin stays high
        step(1'b1, 1'b1, "R1", "R2");
        repeat (10) step(1'b0, 1'b1, "R9", "R3");
        // R4: pin goes low, release to waiting, then pin recharges
        repeat (6) step(1'b0, 1'b0, "R5", "R4");
        repeat (4) step(1'b0, 1'b1, "R4", "R4");
        // R3: fault held while pin reads low
        repeat (3) step(1'b1, 1'b1, "R1", "R2");
        repeat (6) step(1'b1, 1'b0, "R1", "R3");
        repeat (5) step(1'b0, 1'b0, "R5", "R4");
        // R6: refault during waiting
        repeat (3) step(1'b1, 1'b0, "R1", "R6");
        repeat (6) step(1'b0, 1'b0, "R5", "R6");
        repeat (5) step(1'b0, 1'b1, "R4", "R4");
        // R5: pin pulled low externally while idle
        repeat (2) step(1'b0, 1'b0, "R5", "R5");
        repeat (5) step(1'b0, 1'b1, "R9", "R4");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic f, p;
            f = ($urandom % 8) == 0;
            p = ($urandom % 3) != 0;
            step(f, p, f ? "R1" : (p ? "R9" : "R5"), "R3");
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule